// File: doc/BRIEF.md
# Latency-Feedback Active-Warp Limit Controller

This block sits beside one core's warp scheduler and decides how many warps that scheduler may issue from. It observes the core in fixed-length sampling windows. During each window it adds up the round-trip latency and the number of completed interconnect packets, the number of first-level cache accesses and how many of them were bypassed, and whether the shared cache reported contention. When the window closes, it publishes a new warp limit and two enable bits. One bit permits cache bypassing and the other permits throttling.

When no contention was seen, the core runs unthrottled at the full warp count. The first contended window seeds the limit from the bypass ratio, scaled linearly between 2 and 24. A higher bypass ratio gives a higher seed, because bypassing leaves room for more active warps. In later contended windows the limit moves by one step toward an average latency band bounded by two programmable thresholds. This keeps the network busy without congesting it. The window length and both thresholds are configuration inputs held by the parent.

Top module: `warp_limit_ctrl`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `maw` is 48 and both `bypass_en` and `throttle_en` are 0.
- R2: A window lasts `cfg_win_len` cycles, and a value of 0 behaves as 1. The outputs change only on the clock edge that closes a window, so they are visible in the cycle after the window's last cycle.
- R3: If `l2_contend_evt` was never high during a window, then at its close `throttle_en` and `bypass_en` become 0 and `maw` becomes 48.
- R4: If a window saw contention and `throttle_en` was 0, then at its close both enables become 1 and `maw` becomes 2 + floor(22 × bypasses / accesses). With zero accesses the seed is 2.
- R5: With throttling on and contention seen, a window whose latency sum exceeds `cfg_lat_hi` × packets (packets > 0) lowers `maw` by one, but not below 1.
- R6: With throttling on and contention seen, a window with no packets, or with latency sum below `cfg_lat_lo` × packets, raises `maw` by one, but not above 48.
- R7: With throttling on and contention seen, a window whose average latency lies within the band leaves `maw` unchanged.
- R8: Samples and contention presented in a window's last cycle count toward that window. All totals restart from zero in the next window.
- R9: When a window meets both the R5 and R6 conditions (low threshold set above the high one), the R5 decrement applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_win_len | input | 16 | Sampling window length in cycles (0 acts as 1) |
| cfg_lat_hi | input | 10 | Average-latency ceiling of the target band |
| cfg_lat_lo | input | 10 | Average-latency floor of the target band |
| net_lat_inc | input | 13 | Summed round-trip latency of packets completing this cycle |
| net_pkt_inc | input | 3 | Number of packets completing this cycle |
| l1_acc_evt | input | 1 | A first-level cache access occurred this cycle |
| l1_byp_evt | input | 1 | That access was bypassed |
| l2_contend_evt | input | 1 | Shared cache reported contention this cycle |
| maw | output | 6 | Current maximum active warps |
| bypass_en | output | 1 | Bypassing permitted |
| throttle_en | output | 1 | Throttling permitted |

## Verification
Two pairs of functions can meet in one cycle. A window can close in the same cycle that a latency sample and a contention pulse arrive. The bench puts a large latency and the only contention pulse of a window on its final cycle. The result must be a decrement: if the final-cycle inputs were dropped, the limit would instead return to 48 or stay put. The bench then runs a quiet window to show that the totals restarted from zero. The second pair is the hot and cold conditions, which the bench makes true at once by setting the low threshold above the high one; the decrement must win. A behavioural model in the bench tracks every cycle and flags any output change that comes off a window boundary.

// File: rtl/wlc_pkg.sv
// Shared types for the warp-limit controller.
package wlc_pkg;

    // Adjustment chosen from one window's latency figures.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_t;

endpackage

// File: rtl/wlc_window.sv
// Sampling window: counts cycles up to the programmed length and keeps
// saturating totals of latency, packets, accesses and bypasses, plus a
// sticky contention flag. The tot_* outputs include the current cycle's
// inputs, so at win_close they describe the complete window.
// Assumes SUM_W + 1 > LAT_W + NPK_W and CNT_W + 1 > NPK_W.
module wlc_window #(
    parameter int WIN_W = 16,
    parameter int LAT_W = 10,
    parameter int NPK_W = 3,
    parameter int SUM_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WIN_W-1:0]        win_len,
    input  logic [LAT_W+NPK_W-1:0]  lat_inc,
    input  logic [NPK_W-1:0]        pkt_inc,
    input  logic                    acc_evt,
    input  logic                    byp_evt,
    input  logic                    cont_evt,
    output logic                    win_close,
    output logic [SUM_W-1:0]        tot_sum,
    output logic [CNT_W-1:0]        tot_pkt,
    output logic [CNT_W-1:0]        tot_acc,
    output logic [CNT_W-1:0]        tot_byp,
    output logic                    tot_cont
);
    localparam int LI_W = LAT_W + NPK_W;

    logic [WIN_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] pkt_q, acc_q, byp_q;
    logic             cont_q;

    logic [WIN_W:0]   cnt_p1;
    logic [SUM_W:0]   sum_x;
    logic [CNT_W:0]   pkt_x, acc_x, byp_x;

    // Next cycle index and the close decision (length 0 closes every cycle).
    assign cnt_p1    = {1'b0, cnt_q} + {{WIN_W{1'b0}}, 1'b1};
    assign win_close = (cnt_p1 >= {1'b0, win_len});

    // Running totals including this cycle's inputs.
    assign sum_x = {1'b0, sum_q} + {{(SUM_W + 1 - LI_W){1'b0}}, lat_inc};
    assign pkt_x = {1'b0, pkt_q} + {{(CNT_W + 1 - NPK_W){1'b0}}, pkt_inc};
    assign acc_x = {1'b0, acc_q} + {{CNT_W{1'b0}}, acc_evt};
    assign byp_x = {1'b0, byp_q} + {{CNT_W{1'b0}}, (acc_evt & byp_evt)};

    // Saturate each total at its all-ones value.
    assign tot_sum  = sum_x[SUM_W] ? {SUM_W{1'b1}} : sum_x[SUM_W-1:0];
    assign tot_pkt  = pkt_x[CNT_W] ? {CNT_W{1'b1}} : pkt_x[CNT_W-1:0];
    assign tot_acc  = acc_x[CNT_W] ? {CNT_W{1'b1}} : acc_x[CNT_W-1:0];
    assign tot_byp  = byp_x[CNT_W] ? {CNT_W{1'b1}} : byp_x[CNT_W-1:0];
    assign tot_cont = cont_q | cont_evt;

    // Advance the window; clear every total when it closes.
    always_ff @(posedge clk) begin
        if (!rst_n || win_close) begin
            cnt_q  <= '0;
            sum_q  <= '0;
            pkt_q  <= '0;
            acc_q  <= '0;
            byp_q  <= '0;
            cont_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_p1[WIN_W-1:0];
            sum_q  <= tot_sum;
            pkt_q  <= tot_pkt;
            acc_q  <= tot_acc;
            byp_q  <= tot_byp;
            cont_q <= tot_cont;
        end
    end

endmodule

// File: rtl/wlc_judge.sv
// Latency judge: compares a window's latency sum with threshold x packets
// (no divider) and picks down, up or hold. With no packets the network is
// taken as idle (up). The down condition has priority over the up condition.
module wlc_judge
    import wlc_pkg::*;
#(
    parameter int LAT_W = 10,
    parameter int SUM_W = 24,
    parameter int CNT_W = 16
) (
    input  logic [SUM_W-1:0] sum,
    input  logic [CNT_W-1:0] pkts,
    input  logic [LAT_W-1:0] lat_hi,
    input  logic [LAT_W-1:0] lat_lo,
    output step_t            step
);
    localparam int PR_W  = LAT_W + CNT_W;
    localparam int CMP_W = (PR_W > SUM_W) ? PR_W : SUM_W;

    logic [CMP_W-1:0] sum_w, hi_lim, lo_lim;
    logic             no_pkts;

    // Scale the thresholds to the window's packet count.
    assign sum_w   = CMP_W'(sum);
    assign hi_lim  = CMP_W'(lat_hi) * CMP_W'(pkts);
    assign lo_lim  = CMP_W'(lat_lo) * CMP_W'(pkts);
    assign no_pkts = (pkts == '0);

    // Pick the adjustment, congestion first.
    always_comb begin
        if (!no_pkts && (sum_w > hi_lim)) begin
            step = STEP_DOWN;
        end else if (no_pkts || (sum_w < lo_lim)) begin
            step = STEP_UP;
        end else begin
            step = STEP_HOLD;
        end
    end

endmodule

// File: rtl/wlc_seed.sv
// Seed estimator: maps bypasses/accesses linearly onto SEED_MIN..SEED_MAX
// using one comparator per step (k*acc <= SPAN*byp) instead of a divider.
// Assumes byp <= acc and SEED_MAX > SEED_MIN. Zero accesses yields SEED_MIN.
module wlc_seed #(
    parameter int ACC_W    = 16,
    parameter int SEED_MIN = 2,
    parameter int SEED_MAX = 24,
    parameter int MAW_W    = 6
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] byp,
    output logic [MAW_W-1:0] seed
);
    localparam int SPAN = SEED_MAX - SEED_MIN;
    localparam int K_W  = $clog2(SPAN + 1);
    localparam int P_W  = ACC_W + K_W;

    logic [SPAN-1:0] step_ok;
    logic [P_W-1:0]  byp_scaled;

    assign byp_scaled = P_W'(SPAN) * P_W'(byp);

    // One comparator per possible increment above the minimum.
    for (genvar k = 1; k <= SPAN; k++) begin : g_step
        assign step_ok[k-1] = ((P_W'(k) * P_W'(acc)) <= byp_scaled);
    end

    // Count the satisfied steps to form the seed.
    always_comb begin
        if (acc == '0) begin
            seed = MAW_W'(SEED_MIN);
        end else begin
            seed = MAW_W'(SEED_MIN) + MAW_W'($countones(step_ok));
        end
    end

endmodule

// File: rtl/warp_limit_ctrl.sv
// Per-core active-warp limit controller. At every window close it either
// releases throttling (no contention), seeds the limit from the bypass
// ratio (first contended window), or nudges it by one toward the latency
// band. Configuration inputs are expected to change only at window
// boundaries.
module warp_limit_ctrl
    import wlc_pkg::*;
#(
    parameter int MAX_WARPS = 48,
    parameter int SEED_MIN  = 2,
    parameter int SEED_MAX  = 24,
    parameter int WIN_W     = 16,
    parameter int LAT_W     = 10,
    parameter int NPK_W     = 3,
    parameter int SUM_W     = 24,
    parameter int CNT_W     = 16,
    localparam int MAW_W    = $clog2(MAX_WARPS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WIN_W-1:0]       cfg_win_len,
    input  logic [LAT_W-1:0]       cfg_lat_hi,
    input  logic [LAT_W-1:0]       cfg_lat_lo,
    input  logic [LAT_W+NPK_W-1:0] net_lat_inc,
    input  logic [NPK_W-1:0]       net_pkt_inc,
    input  logic                   l1_acc_evt,
    input  logic                   l1_byp_evt,
    input  logic                   l2_contend_evt,
    output logic [MAW_W-1:0]       maw,
    output logic                   bypass_en,
    output logic                   throttle_en
);
    localparam logic [MAW_W-1:0] MAW_FULL = MAW_W'(MAX_WARPS);
    localparam logic [MAW_W-1:0] MAW_ONE  = MAW_W'(1);

    logic             win_close;
    logic [SUM_W-1:0] tot_sum;
    logic [CNT_W-1:0] tot_pkt, tot_acc, tot_byp;
    logic             tot_cont;
    logic [MAW_W-1:0] seed;
    step_t            step;

    logic [MAW_W-1:0] maw_q;
    logic             byp_q, thr_q;

    wlc_window #(
        .WIN_W (WIN_W),
        .LAT_W (LAT_W),
        .NPK_W (NPK_W),
        .SUM_W (SUM_W),
        .CNT_W (CNT_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_len   (cfg_win_len),
        .lat_inc   (net_lat_inc),
        .pkt_inc   (net_pkt_inc),
        .acc_evt   (l1_acc_evt),
        .byp_evt   (l1_byp_evt),
        .cont_evt  (l2_contend_evt),
        .win_close (win_close),
        .tot_sum   (tot_sum),
        .tot_pkt   (tot_pkt),
        .tot_acc   (tot_acc),
        .tot_byp   (tot_byp),
        .tot_cont  (tot_cont)
    );

    wlc_judge #(
        .LAT_W (LAT_W),
        .SUM_W (SUM_W),
        .CNT_W (CNT_W)
    ) u_judge (
        .sum    (tot_sum),
        .pkts   (tot_pkt),
        .lat_hi (cfg_lat_hi),
        .lat_lo (cfg_lat_lo),
        .step   (step)
    );

    wlc_seed #(
        .ACC_W    (CNT_W),
        .SEED_MIN (SEED_MIN),
        .SEED_MAX (SEED_MAX),
        .MAW_W    (MAW_W)
    ) u_seed (
        .acc  (tot_acc),
        .byp  (tot_byp),
        .seed (seed)
    );

    // Update limit and enables once per window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maw_q <= MAW_FULL;
            byp_q <= 1'b0;
            thr_q <= 1'b0;
        end else if (win_close) begin
            if (!tot_cont) begin
                maw_q <= MAW_FULL;
                byp_q <= 1'b0;
                thr_q <= 1'b0;
            end else if (!thr_q) begin
                maw_q <= seed;
                byp_q <= 1'b1;
                thr_q <= 1'b1;
            end else begin
                byp_q <= 1'b1;
                if (step == STEP_DOWN && maw_q > MAW_ONE) begin
                    maw_q <= maw_q - MAW_ONE;
                end else if (step == STEP_UP && maw_q < MAW_FULL) begin
                    maw_q <= maw_q + MAW_ONE;
                end
            end
        end
    end

    assign maw         = maw_q;
    assign bypass_en   = byp_q;
    assign throttle_en = thr_q;

endmodule

// File: rtl/wlc_checker.sv
// Property checker for warp_limit_ctrl, attached with bind below.
// Assumes the same parameter values as the controller it watches.
module wlc_checker #(
    parameter int MAX_WARPS = 48,
    parameter int SEED_MIN  = 2,
    parameter int SEED_MAX  = 24,
    parameter int MAW_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_close,
    input logic [MAW_W-1:0] maw,
    input logic             throttle_en,
    input logic             bypass_en
);
    // R2: outputs move only on a closing edge.
    assert_quiet_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_close |=> ($stable(maw) && $stable(throttle_en) && $stable(bypass_en)));

    // R3: unthrottled means the full warp count.
    assert_full_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !throttle_en |-> (maw == MAW_W'(MAX_WARPS)));

    // R4: a freshly seeded limit lies on the seed scale.
    assert_seed_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle_en) |-> (maw >= MAW_W'(SEED_MIN) && maw <= MAW_W'(SEED_MAX)));

    // R5/R6: while throttling stays on, one step at most per window.
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_en && $past(throttle_en)) |->
            (maw == $past(maw) || maw == $past(maw) + MAW_W'(1) || maw + MAW_W'(1) == $past(maw)));

    // R6: the limit never leaves 1..MAX_WARPS.
    assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (maw >= MAW_W'(1) && maw <= MAW_W'(MAX_WARPS)));

endmodule

bind warp_limit_ctrl wlc_checker #(
    .MAX_WARPS (MAX_WARPS),
    .SEED_MIN  (SEED_MIN),
    .SEED_MAX  (SEED_MAX),
    .MAW_W     (MAW_W)
) u_wlc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_close   (win_close),
    .maw         (maw),
    .throttle_en (throttle_en),
    .bypass_en   (bypass_en)
);

// File: tb/warp_limit_ctrl_test.sv
// Bench for warp_limit_ctrl: a behavioural integer model runs alongside
// and is compared on every falling edge; directed checks pin key values.
module warp_limit_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_win_len = 16'd4;
    logic [9:0]  cfg_lat_hi = 10'd100;
    logic [9:0]  cfg_lat_lo = 10'd40;
    logic [12:0] net_lat_inc = '0;
    logic [2:0]  net_pkt_inc = '0;
    logic        l1_acc_evt = 1'b0;
    logic        l1_byp_evt = 1'b0;
    logic        l2_contend_evt = 1'b0;
    logic [5:0]  maw;
    logic        bypass_en, throttle_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int r_maw = 48, r_thr = 0, r_cnt = 0;
    int r_sum = 0, r_pkt = 0, r_acc = 0, r_byp = 0, r_con = 0;

    warp_limit_ctrl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_win_len    (cfg_win_len),
        .cfg_lat_hi     (cfg_lat_hi),
        .cfg_lat_lo     (cfg_lat_lo),
        .net_lat_inc    (net_lat_inc),
        .net_pkt_inc    (net_pkt_inc),
        .l1_acc_evt     (l1_acc_evt),
        .l1_byp_evt     (l1_byp_evt),
        .l2_contend_evt (l2_contend_evt),
        .maw            (maw),
        .bypass_en      (bypass_en),
        .throttle_en    (throttle_en)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model of the window rules.
    always @(posedge clk) begin
        if (!rst_n) begin
            r_maw = 48; r_thr = 0; r_cnt = 0;
            r_sum = 0; r_pkt = 0; r_acc = 0; r_byp = 0; r_con = 0;
        end else begin
            int wl;
            r_sum += int'(net_lat_inc);
            r_pkt += int'(net_pkt_inc);
            r_acc += int'(l1_acc_evt);
            r_byp += int'(l1_acc_evt && l1_byp_evt);
            if (l2_contend_evt) r_con = 1;
            r_cnt++;
            wl = (cfg_win_len == 0) ? 1 : int'(cfg_win_len);
            if (r_cnt >= wl) begin
                if (r_con == 0) begin
                    r_maw = 48; r_thr = 0;
                end else if (r_thr == 0) begin
                    r_thr = 1;
                    r_maw = (r_acc == 0) ? 2 : 2 + (22 * r_byp) / r_acc;
                end else if (r_pkt > 0 && r_sum > int'(cfg_lat_hi) * r_pkt) begin
                    if (r_maw > 1) r_maw--;
                end else if (r_pkt == 0 || r_sum < int'(cfg_lat_lo) * r_pkt) begin
                    if (r_maw < 48) r_maw++;
                end
                r_cnt = 0; r_sum = 0; r_pkt = 0; r_acc = 0; r_byp = 0; r_con = 0;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_req, " maw"}, int'(maw), r_maw);
            check({cur_req, " throttle_en"}, int'(throttle_en), r_thr);
            check({cur_req, " bypass_en"}, int'(bypass_en), r_thr);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input int lat, input int pk, input int acc, input int byp, input int con);
        net_lat_inc    = 13'(lat);
        net_pkt_inc    = 3'(pk);
        l1_acc_evt     = 1'(acc);
        l1_byp_evt     = 1'(byp);
        l2_contend_evt = 1'(con);
        @(negedge clk);
    endtask

    task automatic win(input int n, input int lat, input int pk, input int acc, input int byp, input int con);
        for (int i = 0; i < n; i++) cyc(lat, pk, acc, byp, con);
    endtask

    task automatic outs(input string req, input int m, input int t);
        check({req, " maw"}, int'(maw), m);
        check({req, " throttle_en"}, int'(throttle_en), t);
        check({req, " bypass_en"}, int'(bypass_en), t);
    endtask

    initial begin
        // R1: reset state, during and right after reset.
        repeat (3) @(negedge clk);
        outs("R1", 48, 0);
        rst_n = 1'b1;
        @(negedge clk);
        outs("R1", 48, 0);
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);  // finish window 1

        // R3: traffic but no contention keeps full width.
        cur_req = "R3";
        win(4, 50, 1, 1, 0, 0);
        outs("R3", 48, 0);

        // R4: acc=4, byp=2 -> 2 + 44/4 = 13.
        cur_req = "R4";
        cyc(0, 0, 1, 1, 1); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
        outs("R4", 13, 1);

        // R5: average 200 > 100 -> down.
        cur_req = "R5";
        win(4, 200, 1, 0, 0, 1);
        outs("R5", 12, 1);

        // R6: no packets -> up.
        cur_req = "R6";
        win(4, 0, 0, 0, 0, 1);
        outs("R6", 13, 1);

        // R7: average 60 inside 40..100 -> hold; also mid-window stability (R2).
        cur_req = "R7";
        cyc(60, 1, 0, 0, 1); cyc(60, 1, 0, 0, 1);
        outs("R2", 13, 1);
        cyc(60, 1, 0, 0, 1); cyc(60, 1, 0, 0, 1);
        outs("R7", 13, 1);

        // R8: big latency and the only contention on the closing cycle.
        cur_req = "R8";
        cyc(60, 1, 0, 0, 0); cyc(60, 1, 0, 0, 0); cyc(60, 1, 0, 0, 0); cyc(700, 1, 0, 0, 1);
        outs("R8", 12, 1);
        // R8: totals restarted, so an in-band window holds.
        win(4, 60, 1, 0, 0, 1);
        outs("R8", 12, 1);

        // R9: low threshold above high one, both hot and cold true -> down.
        cur_req = "R9";
        cfg_lat_lo = 10'd300;
        win(4, 200, 1, 0, 0, 1);
        outs("R9", 11, 1);
        cfg_lat_lo = 10'd40;

        // R5: one-cycle windows drive the limit to its floor of 1 (R2 length 1).
        cur_req = "R5";
        cfg_win_len = 16'd1;
        win(15, 200, 1, 0, 0, 1);
        outs("R5", 1, 1);

        // R6: length 0 behaves as 1; climbing stops at 48.
        cur_req = "R6";
        cfg_win_len = 16'd0;
        win(50, 0, 0, 0, 0, 1);
        outs("R6", 48, 1);

        // R3: lower once, then a quiet window releases throttling.
        cur_req = "R3";
        cfg_win_len = 16'd3;
        win(3, 200, 1, 0, 0, 1);
        outs("R5", 47, 1);
        win(3, 200, 1, 0, 0, 0);
        outs("R3", 48, 0);

        // R4: zero accesses seeds the minimum of 2.
        cur_req = "R4";
        win(3, 0, 0, 0, 0, 1);
        outs("R4", 2, 1);
        win(3, 0, 0, 0, 0, 0);
        outs("R3", 48, 0);
        // R4: every access bypassed seeds the maximum of 24.
        win(3, 0, 0, 1, 1, 1);
        outs("R4", 24, 1);

        // R2: a 5-cycle window changes nothing until its fifth cycle.
        cur_req = "R2";
        cfg_win_len = 16'd5;
        win(4, 200, 1, 0, 0, 1);
        outs("R2", 24, 1);
        cyc(200, 1, 0, 0, 1);
        outs("R2", 23, 1);

        cyc(0, 0, 0, 0, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule